// File: doc/BRIEF.md
# Changeover-Switch Debouncer with Reflected-Binary Step Counter

This block takes the two contact lines of a break-before-make changeover switch and produces one clean level, so that each flip of the lever gives exactly one rising or falling transition. That level then drives a 2-bit counter, which moves one position in reflected-binary order on every rising transition. The debounce element is a set/reset hold element, not a timer. While the lever travels, or while a contact chatters, neither contact is made or only the contact just reached is made, so the element keeps its last value. Only the opposite contact can change it.

Both contact lines cross into the system clock domain through a parameterised synchroniser before they reach the hold element. A parameter selects the electrical sense of the contact lines. With the low-true sense, a closed contact pulls its line low, as a cross-coupled NAND pair would expect. With the high-true sense, a closed contact drives its line high, as for a NOR pair. A second parameter selects how the counter is built: plain data flip-flops with next-state equations, or a toggle stage on the upper bit with a J/K stage on the lower bit. An asynchronous start input forces the count to zero at any time.

Top module: `flip_gray_counter`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it is released, `level_o` is 0 and `count_o` is 2'b00.
- R2: When only the far contact is closed, `level_o` becomes 1. When only the rest contact is closed, `level_o` becomes 0. A change on the pins is first visible on `level_o` after SYNC_STAGES+1 rising clock edges.
- R3: When neither contact is closed, `level_o` and `count_o` keep their values, however long this lasts.
- R4: When both contacts are closed at once (an illegal input), `level_o` keeps its value and the count does not step.
- R5: `count_o` moves one step in the cycle where `level_o` rises, in the order 00, 01, 11, 10, then back to 00 (bit 1 is the MSB). A fall of `level_o` does not step the count.
- R6: A flip of the lever produces exactly one count step when it goes to the far contact and none when it goes to the rest contact, for any burst of chatter on the releasing or the making contact.
- R7: `start` high forces `count_o` to 00 at once, with no clock edge needed. The count holds 00 while `start` stays high, and `level_o` is not affected.
- R8: With CONTACT_LOW_TRUE=1, a closed contact is signalled by a 0 on its pin. Given inverted pins, the block behaves cycle for cycle like the high-true build.
- R9: With CNT_STYLE=1 (toggle stage for bit 1, J/K stage for bit 0), the count sequence and its timing match the CNT_STYLE=0 data flip-flop build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block |
| start | input | 1 | Asynchronous active-high clear of the count |
| contact_home | input | 1 | Rest-side contact line; its sense is set by CONTACT_LOW_TRUE |
| contact_away | input | 1 | Far-side contact line; its sense is set by CONTACT_LOW_TRUE |
| level_o | output | 1 | Debounced switch level: 1 at the far contact, 0 at the rest contact |
| count_o | output | 2 | Count in reflected-binary order, active high |

## Verification
The bench builds two copies with SYNC_STAGES=2. The first uses high-true contacts and data flip-flops. The second uses low-true contacts and the toggle and J/K counter, and is fed the inverted pins, so both polarity branches and both counter branches run against the same reference model on every clock. The two-stage depth keeps the latency of R2 short enough to check edge by edge. Random chatter bursts, with random lengths and gaps, are injected on both the releasing and the making contact. The illegal both-closed pattern is driven from each lever position, and `start` is asserted between clock edges, so R4, R6 and R7 are exercised against both builds.

// File: rtl/fgc_pkg.sv
`timescale 1ns/1ps
package fgc_pkg;
   localparam int CountW = 2;

   typedef logic [CountW-1:0] gray_t;

   // closure pattern, bit 1 = rest contact, bit 0 = far contact
   typedef enum logic [1:0] {
      CT_OPEN = 2'b00,
      CT_AWAY = 2'b01,
      CT_HOME = 2'b10,
      CT_BOTH = 2'b11
   } contact_e;

   function automatic gray_t gray_advance(gray_t q);
      return {q[0], ~q[1]};
   endfunction
endpackage

// File: rtl/fgc_sync.sv
`timescale 1ns/1ps
module fgc_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int LastIdx = STAGES - 1;

   logic [WIDTH-1:0] stage [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage[s] <= '0;
      end else begin
         stage[0] <= d;
         for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
      end
   end

   assign q = stage[LastIdx];
endmodule

// File: rtl/fgc_contact_latch.sv
`timescale 1ns/1ps
module fgc_contact_latch
   import fgc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  contact_e closed,
   output logic     level_o,
   output logic     rise_o
);
   logic level_q;
   logic level_d;

   // far contact sets, rest contact clears; open or illegal both hold
   always_comb begin
      unique case (closed)
         CT_AWAY: level_d = 1'b1;
         CT_HOME: level_d = 1'b0;
         default: level_d = level_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level_d;
   end

   assign rise_o  = level_d & ~level_q;
   assign level_o = level_q;
endmodule

// File: rtl/fgc_gray_step.sv
`timescale 1ns/1ps
module fgc_gray_step
   import fgc_pkg::*;
#(
   parameter int STYLE = 0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  clr,
   input  logic  step,
   output gray_t count_o
);
   generate
      if (STYLE == 0) begin : g_dff
         gray_t q;
         always_ff @(posedge clk or negedge rst_n or posedge clr) begin
            if (!rst_n || clr) q <= '0;
            else if (step)     q <= gray_advance(q);
         end
         assign count_o = q;
      end else begin : g_tjk
         logic b1, b0;
         logic t1, j0, k0;
         assign t1 = b1 ^ b0;
         assign j0 = ~b1;
         assign k0 = b1;

         always_ff @(posedge clk or negedge rst_n or posedge clr) begin
            if (!rst_n || clr)   b1 <= 1'b0;
            else if (step && t1) b1 <= ~b1;
         end

         always_ff @(posedge clk or negedge rst_n or posedge clr) begin
            if (!rst_n || clr) b0 <= 1'b0;
            else if (step) begin
               unique case ({j0, k0})
                  2'b10:   b0 <= 1'b1;
                  2'b01:   b0 <= 1'b0;
                  2'b11:   b0 <= ~b0;
                  default: b0 <= b0;
               endcase
            end
         end
         assign count_o = {b1, b0};
      end
   endgenerate
endmodule

// File: rtl/flip_gray_counter.sv
`timescale 1ns/1ps
module flip_gray_counter
   import fgc_pkg::*;
#(
   parameter int SYNC_STAGES      = 2,
   parameter bit CONTACT_LOW_TRUE = 1'b0,
   parameter int CNT_STYLE        = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              contact_home,
   input  logic              contact_away,
   output logic              level_o,
   output logic [CountW-1:0] count_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("flip_gray_counter: SYNC_STAGES must be at least 2");
      end
      if (CNT_STYLE != 0 && CNT_STYLE != 1) begin : g_bad_style
         $error("flip_gray_counter: CNT_STYLE must be 0 or 1");
      end
   endgenerate

   logic [1:0] closed_raw;
   logic [1:0] closed_s;
   logic       home_closed_s;
   logic       away_closed_s;
   logic       rise;

   generate
      if (CONTACT_LOW_TRUE) begin : g_low_true
         assign closed_raw = {~contact_home, ~contact_away};
      end else begin : g_high_true
         assign closed_raw = {contact_home, contact_away};
      end
   endgenerate

   fgc_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (closed_raw),
      .q     (closed_s)
   );

   assign home_closed_s = closed_s[1];
   assign away_closed_s = closed_s[0];

   fgc_contact_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .closed  (contact_e'(closed_s)),
      .level_o (level_o),
      .rise_o  (rise)
   );

   fgc_gray_step #(.STYLE(CNT_STYLE)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .step    (rise),
      .count_o (count_o)
   );
endmodule

// File: rtl/flip_gray_counter_chk.sv
`timescale 1ns/1ps
module flip_gray_counter_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       home_c,
   input logic       away_c,
   input logic       level,
   input logic [1:0] count
);
   function automatic logic [1:0] seq_after(logic [1:0] c);
      case (c)
         2'b00:   return 2'b01;
         2'b01:   return 2'b11;
         2'b11:   return 2'b10;
         default: return 2'b00;
      endcase
   endfunction

   assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (away_c && !home_c) |=> level);

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (home_c && !away_c) |=> !level);

   assert_hold_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!home_c && !away_c) |=> $stable(level));

   assert_hold_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (home_c && away_c) |=> $stable(level));

   assert_step_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count) && !start && !$past(start))
         |-> count == seq_after($past(count)));

   assert_step_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count) && !start && !$past(start)) |-> $rose(level));

   assert_start_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> count == 2'b00);
endmodule

bind flip_gray_counter flip_gray_counter_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .home_c (home_closed_s),
   .away_c (away_closed_s),
   .level  (level_o),
   .count  (count_o)
);

// File: tb/sim_flip_gray_counter.sv
`timescale 1ns/1ps
module sim_flip_gray_counter;
   localparam int SYNC_N = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic home  = 1'b1;
   logic away  = 1'b0;

   logic       lvl0, lvl1;
   logic [1:0] cnt0, cnt1;

   flip_gray_counter #(.SYNC_STAGES(SYNC_N), .CONTACT_LOW_TRUE(1'b0), .CNT_STYLE(0)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .contact_home(home), .contact_away(away),
      .level_o(lvl0), .count_o(cnt0));

   flip_gray_counter #(.SYNC_STAGES(SYNC_N), .CONTACT_LOW_TRUE(1'b1), .CNT_STYLE(1)) u1 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .contact_home(~home), .contact_away(~away),
      .level_o(lvl1), .count_o(cnt1));

   int checks = 0;
   int errors = 0;
   bit done   = 0;
   string cur_req = "R2";

   function automatic logic [1:0] gcode(int idx);
      case (idx % 4)
         0:       return 2'b00;
         1:       return 2'b01;
         2:       return 2'b11;
         default: return 2'b10;
      endcase
   endfunction

   task automatic check(string req, string what, logic [1:0] act, logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   // behavioural reference: queue of sampled closures, hold flag, step index
   logic [1:0] pipe [$];
   logic m_level = 1'b0;
   int   m_idx   = 0;

   always @(posedge start) m_idx = 0;

   always @(posedge clk) begin
      logic [1:0] oldest;
      if (!rst_n) begin
         pipe.delete();
         for (int i = 0; i < SYNC_N; i++) pipe.push_back(2'b00);
         m_level = 1'b0;
         m_idx = 0;
      end else begin
         oldest = pipe.pop_front();
         pipe.push_back({home, away});
         if (oldest == 2'b01) begin
            if (!m_level && !start) m_idx = (m_idx + 1) % 4;
            m_level = 1'b1;
         end else if (oldest == 2'b10) begin
            m_level = 1'b0;
         end
         if (start) m_idx = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(cur_req, "u0 level vs model", {1'b0, lvl0}, {1'b0, m_level});
         check(cur_req, "u0 count vs model", cnt0, gcode(m_idx));
         check("R8", "u1 level vs model", {1'b0, lvl1}, {1'b0, m_level});
         check("R9", "u1 count vs model", cnt1, gcode(m_idx));
      end
   end

   int ex_idx = 0;

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_contact(bit is_away, logic val);
      if (is_away) away = val;
      else         home = val;
   endtask

   task automatic flip(bit to_away, int bounces);
      for (int k = 0; k < bounces; k++) begin
         set_contact(!to_away, (k % 2) ? 1'b1 : 1'b0);
         wait_cyc($urandom_range(3, 1));
      end
      set_contact(!to_away, 1'b0);
      wait_cyc($urandom_range(5, 2));
      for (int k = 0; k < bounces; k++) begin
         set_contact(to_away, (k % 2) ? 1'b0 : 1'b1);
         wait_cyc($urandom_range(3, 1));
      end
      set_contact(to_away, 1'b1);
      wait_cyc(SYNC_N + 3);
      if (to_away && !start) ex_idx++;
      check("R6", "count after flip", cnt0, gcode(ex_idx));
      check("R6", "u1 count after flip", cnt1, gcode(ex_idx));
      check("R2", "level after flip", {1'b0, lvl0}, {1'b0, to_away});
   endtask

   initial begin
      wait_cyc(3);
      check("R1", "level in reset", {1'b0, lvl0}, 2'b00);
      check("R1", "count in reset", cnt0, 2'b00);
      check("R1", "u1 count in reset", cnt1, 2'b00);
      rst_n = 1'b1;
      wait_cyc(1);
      check("R1", "level after release", {1'b0, lvl0}, 2'b00);
      wait_cyc(SYNC_N + 2);

      // R2 latency: clean move to the far contact
      cur_req = "R2";
      home = 1'b0; away = 1'b1;
      wait_cyc(SYNC_N);
      check("R2", "level before latency", {1'b0, lvl0}, 2'b00);
      wait_cyc(1);
      check("R2", "level after latency", {1'b0, lvl0}, 2'b01);
      ex_idx = 1;
      check("R5", "first step", cnt0, 2'b01);
      wait_cyc(2);

      // R5 full walk with clean flips
      cur_req = "R5";
      for (int n = 0; n < 4; n++) begin
         flip(1'b0, 0);
         check("R5", "no step on fall", cnt0, gcode(ex_idx));
         flip(1'b1, 0);
      end

      // R3 long open interval
      cur_req = "R3";
      away = 1'b0;
      wait_cyc(40);
      check("R3", "level held open", {1'b0, lvl0}, 2'b01);
      check("R3", "count held open", cnt0, gcode(ex_idx));
      away = 1'b1;
      wait_cyc(SYNC_N + 3);

      // R4 both closed from the far position, then from the rest position
      cur_req = "R4";
      home = 1'b1;
      wait_cyc(8);
      check("R4", "level both from far", {1'b0, lvl0}, 2'b01);
      check("R4", "count both from far", cnt0, gcode(ex_idx));
      away = 1'b0;
      wait_cyc(SYNC_N + 3);
      check("R4", "level to rest", {1'b0, lvl0}, 2'b00);
      away = 1'b1;
      wait_cyc(8);
      check("R4", "level both from rest", {1'b0, lvl0}, 2'b00);
      check("R4", "count both from rest", cnt0, gcode(ex_idx));
      home = 1'b0;
      wait_cyc(SYNC_N + 3);
      ex_idx++;
      check("R4", "step after leaving illegal", cnt0, gcode(ex_idx));

      // R6 chatter bursts
      cur_req = "R6";
      for (int n = 0; n < 24; n++) begin
         flip(1'b0, $urandom_range(9, 1));
         flip(1'b1, $urandom_range(9, 1));
      end

      // R7 asynchronous start between edges
      cur_req = "R7";
      flip(1'b0, 2);
      @(negedge clk);
      #2 start = 1'b1;
      #1;
      ex_idx = 0;
      check("R7", "count cleared without edge", cnt0, 2'b00);
      check("R7", "u1 count cleared without edge", cnt1, 2'b00);
      check("R7", "level untouched", {1'b0, lvl0}, 2'b00);
      flip(1'b1, 3);
      check("R7", "count held under start", cnt0, 2'b00);
      flip(1'b0, 3);
      start = 1'b0;
      wait_cyc(2);
      flip(1'b1, 4);
      check("R7", "count resumes", cnt0, 2'b01);
      check("R9", "u1 matches u0", cnt1, cnt0);
      check("R8", "u1 level matches u0", {1'b0, lvl1}, {1'b0, lvl0});

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule